// File: doc/BRIEF.md
# DES Round Subkey Generator

This block turns a 64-bit DES key into the sixteen 48-bit round subkeys, one per round, in the order the cipher datapath needs them. A key load drops one bit of every byte, permutes the remaining 56 bits through the first permuted choice and holds the result as two independent 28-bit halves. Each round-advance strobe then rotates both halves and presents the second permuted choice of the rotated halves as the subkey for that round.

The rotation is not done by a barrel rotator. A small sequencer walks a fixed 32-step sequence of two sub-steps per round. In each sub-step it either issues a single-position shift enable to both halves or issues none, so a round rotates by zero, one or two positions. In the encrypt direction the halves rotate left and the subkeys come out first to last. In the decrypt direction they rotate right, by nothing before the first round and by the encrypt amounts in reverse order after that, so the subkeys come out last to first without a second key schedule. The direction is captured with the key. A pass ends after sixteen rounds, and a new key load starts the next pass.

Top module: `des_key_sched`

## Requirements
- R1: After reset, `subkey_vld` is 0 and `subkey` is all zeros.
- R2: A key load ignores the eight parity bits `key_in[0]`, `key_in[8]`, ..., `key_in[56]`. Flipping any of them changes no subkey of the pass.
- R3: In encrypt direction (`decrypt`=0 at load), the subkey after the n-th round is the standard DES subkey K(n). `key_in[63]` is key bit 1 and `subkey[47]` is subkey bit 1. The halves rotate left by 1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1 positions in rounds 1 to 16.
- R4: In decrypt direction (`decrypt`=1 at load), the subkey after the n-th round is K(17-n). The first round gives K16, which is the second permuted choice of the freshly loaded halves.
- R5: A strobe accepted at a rising edge drives `subkey_vld` low for one cycle. `subkey_vld` returns high one cycle later with the new subkey, two edges after the strobe was sampled.
- R6: A strobe that arrives while a round is still in its second sub-step is ignored. Strobes after the sixteenth round are ignored: `subkey` and `subkey_vld` hold.
- R7: `decrypt` is sampled only with `key_load`. Changing it during a pass has no effect on the subkey order.
- R8: `key_load` takes priority over a simultaneous `round_adv`. The load clears `subkey_vld` and restarts the round count, so the next round yields the first subkey of the new pass.
- R9: The sixteen encrypt rotations total 28 positions. After round 16 the halves hold their loaded values again, so K16 equals the subkey of the loaded halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_load | input | 1 | Load `key_in` and capture `decrypt`; restarts the pass |
| key_in | input | 64 | Key, bit 1 at index 63, parity bits at indices 8k |
| decrypt | input | 1 | Direction captured at load: 0 encrypt order, 1 decrypt order |
| round_adv | input | 1 | Round-advance strobe |
| subkey | output | 48 | Subkey for the current round, bit 1 at index 47 |
| subkey_vld | output | 1 | Subkey of the latest accepted round is ready |

## Verification
A wrong sub-step enable or a wrong rotation direction corrupts every following subkey. Such a fault shows at `subkey` two edges after the strobe of the faulty round and is never repaired within the pass. A miscounted sequencer state shows either as a wrong subkey for the round or as a pass that stops early or runs past sixteen rounds. The bench therefore compares every subkey of full passes in both directions against a reference model, and checks the single known first-round subkey of a standard key, so that errors in the bit ordering or in the permutation tables do not cancel out.

// File: rtl/des_ks_pkg.sv
package des_ks_pkg;
  localparam int KEY_W  = 64;
  localparam int HALF_W = 28;
  localparam int CD_W   = 2 * HALF_W;
  localparam int SUB_W  = 48;
  localparam int ROUNDS = 16;
  localparam int IDX_W  = $clog2(ROUNDS);
  localparam int RND_W  = $clog2(ROUNDS + 1);

  // rounds (0-based) whose second sub-step also shifts; same set in both directions
  localparam logic [ROUNDS-1:0] DOUBLE_MASK = 16'h7EFC;

  // first permuted choice: key bit numbers (1 = key_in MSB) for CD bits 1..56
  localparam int PC1_TAB [CD_W] = '{
    57, 49, 41, 33, 25, 17,  9,  1, 58, 50, 42, 34, 26, 18,
    10,  2, 59, 51, 43, 35, 27, 19, 11,  3, 60, 52, 44, 36,
    63, 55, 47, 39, 31, 23, 15,  7, 62, 54, 46, 38, 30, 22,
    14,  6, 61, 53, 45, 37, 29, 21, 13,  5, 28, 20, 12,  4
  };

  // second permuted choice: CD bit numbers for subkey bits 1..48
  localparam int PC2_TAB [SUB_W] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };

  function automatic logic [CD_W-1:0] pc2_used_mask();
    logic [CD_W-1:0] m;
    m = '0;
    for (int i = 0; i < SUB_W; i++) m[CD_W - PC2_TAB[i]] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/des_ks_pc1.sv
module des_ks_pc1
  import des_ks_pkg::*;
(
  input  logic [KEY_W-1:0] key,
  output logic [CD_W-1:0]  cd
);
  localparam logic [KEY_W-1:0] PARITY_BITS = 64'h0101_0101_0101_0101;

  logic unused_parity;
  assign unused_parity = ^(key & PARITY_BITS);

  for (genvar i = 0; i < CD_W; i++) begin : g_sel
    assign cd[CD_W-1-i] = key[KEY_W - PC1_TAB[i]];
  end
endmodule

// File: rtl/des_ks_pc2.sv
module des_ks_pc2
  import des_ks_pkg::*;
(
  input  logic [CD_W-1:0]  cd,
  output logic [SUB_W-1:0] subkey
);
  localparam logic [CD_W-1:0] USED = pc2_used_mask();

  logic unused_dropped;
  assign unused_dropped = ^(cd & ~USED);

  for (genvar i = 0; i < SUB_W; i++) begin : g_sel
    assign subkey[SUB_W-1-i] = cd[CD_W - PC2_TAB[i]];
  end
endmodule

// File: rtl/des_ks_rot.sv
module des_ks_rot #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         dir_right,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (load)
      q_d = load_val;
    else if (shift_en)
      q_d = dir_right ? {q[0], q[W-1:1]} : {q[W-2:0], q[W-1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_d;
  end

  // R6: without a load or a sub-step enable the half keeps its value
  a_r6_half_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift_en) |=> $stable(q));

  // R3: one sub-step moves the half by exactly one position, bit count kept
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && shift_en) |=> ($countones(q) == $countones($past(q))));
endmodule

// File: rtl/des_ks_seq.sv
module des_ks_seq
  import des_ks_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic key_load,
  input  logic decrypt,
  input  logic round_adv,
  output logic shift_en,
  output logic dir_right,
  output logic subkey_vld
);
  logic [RND_W-1:0] rnd_q, rnd_d;
  logic             busy_q, busy_d;
  logic             dec_q, dec_d;
  logic             vld_q, vld_d;
  logic             can_start;

  assign can_start = round_adv && (rnd_q < RND_W'(ROUNDS));

  always_comb begin
    rnd_d    = rnd_q;
    busy_d   = busy_q;
    dec_d    = dec_q;
    vld_d    = vld_q;
    shift_en = 1'b0;
    if (key_load) begin
      rnd_d  = '0;
      busy_d = 1'b0;
      dec_d  = decrypt;
      vld_d  = 1'b0;
    end else if (busy_q) begin
      // second sub-step of the round
      shift_en = DOUBLE_MASK[rnd_q[IDX_W-1:0]];
      busy_d   = 1'b0;
      vld_d    = 1'b1;
      rnd_d    = rnd_q + 1'b1;
    end else if (can_start) begin
      // first sub-step: skipped only for the opening decrypt round
      shift_en = !(dec_q && (rnd_q == '0));
      busy_d   = 1'b1;
      vld_d    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rnd_q  <= '0;
      busy_q <= 1'b0;
      dec_q  <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      rnd_q  <= rnd_d;
      busy_q <= busy_d;
      dec_q  <= dec_d;
      vld_q  <= vld_d;
    end
  end

  assign dir_right  = dec_q;
  assign subkey_vld = vld_q;

  // R5: an accepted strobe drops valid, the next edge raises it again
  a_r5_strobe_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!key_load && !busy_q && can_start) |=> (busy_q && !subkey_vld));
  a_r5_valid_after_step: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !key_load) |=> (subkey_vld && !busy_q));

  // R8: load restarts the pass
  a_r8_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    key_load |=> (rnd_q == '0 && !busy_q && !subkey_vld));

  // R6: pass never exceeds its round count and stalls at the end
  a_r6_round_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rnd_q <= RND_W'(ROUNDS));
  a_r6_done_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (rnd_q == RND_W'(ROUNDS) && !key_load) |=> ($stable(rnd_q) && $stable(subkey_vld)));

  // R7: direction changes only with a load
  a_r7_dir_held: assert property (@(posedge clk) disable iff (!rst_n)
    !key_load |=> $stable(dir_right));
endmodule

// File: rtl/des_key_sched.sv
module des_key_sched
  import des_ks_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_load,
  input  logic [KEY_W-1:0]  key_in,
  input  logic              decrypt,
  input  logic              round_adv,
  output logic [SUB_W-1:0]  subkey,
  output logic              subkey_vld
);
  logic [1:0]      rst_sync;
  logic            rst_int_n;
  logic [CD_W-1:0] cd_load;
  logic [CD_W-1:0] cd_q;
  logic            shift_en;
  logic            dir_right;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  des_ks_pc1 u_pc1 (
    .key (key_in),
    .cd  (cd_load)
  );

  des_ks_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .key_load   (key_load),
    .decrypt    (decrypt),
    .round_adv  (round_adv),
    .shift_en   (shift_en),
    .dir_right  (dir_right),
    .subkey_vld (subkey_vld)
  );

  // upper half C and lower half D: identical shifters that never exchange bits
  for (genvar h = 0; h < 2; h++) begin : g_half
    des_ks_rot #(.W(HALF_W)) u_rot (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .load      (key_load),
      .load_val  (cd_load[CD_W-1-h*HALF_W -: HALF_W]),
      .shift_en  (shift_en),
      .dir_right (dir_right),
      .q         (cd_q[CD_W-1-h*HALF_W -: HALF_W])
    );
  end

  des_ks_pc2 u_pc2 (
    .cd     (cd_q),
    .subkey (subkey)
  );
endmodule

// File: tb/des_key_sched_test.sv
module des_key_sched_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        key_load;
  logic [63:0] key_in;
  logic        decrypt;
  logic        round_adv;
  logic [47:0] subkey;
  logic        subkey_vld;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  des_key_sched uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_load   (key_load),
    .key_in     (key_in),
    .decrypt    (decrypt),
    .round_adv  (round_adv),
    .subkey     (subkey),
    .subkey_vld (subkey_vld)
  );

  localparam int PC2_REF [48] = '{
    14, 17, 11, 24,  1,  5,  3, 28, 15,  6, 21, 10,
    23, 19, 12,  4, 26,  8, 16,  7, 27, 20, 13,  2,
    41, 52, 31, 37, 47, 55, 30, 40, 51, 45, 33, 48,
    44, 49, 39, 56, 34, 53, 46, 42, 50, 36, 29, 32
  };
  localparam int ROT_REF [16] = '{1,1,2,2,2,2,2,2,1,2,2,2,2,2,2,1};

  // reference: first permuted choice built from its arithmetic pattern
  function automatic logic [55:0] ref_pc1(input logic [63:0] k);
    logic [55:0] cd;
    for (int i = 0; i < 28; i++) begin
      int p = 57 + i / 8 - 8 * (i % 8);
      cd[55 - i] = k[64 - p];
    end
    for (int j = 0; j < 28; j++) begin
      int p = (j < 24) ? (63 - j / 8 - 8 * (j % 8)) : (28 - 8 * (j - 24));
      cd[27 - j] = k[64 - p];
    end
    return cd;
  endfunction

  // encrypt-order subkey n (1..16)
  function automatic logic [47:0] ref_sub(input logic [63:0] k, input int n);
    logic [55:0] cd;
    logic [27:0] c, d;
    logic [47:0] s;
    cd = ref_pc1(k);
    c = cd[55:28];
    d = cd[27:0];
    for (int r = 0; r < n; r++)
      for (int s2 = 0; s2 < ROT_REF[r]; s2++) begin
        c = {c[26:0], c[27]};
        d = {d[26:0], d[27]};
      end
    cd = {c, d};
    for (int i = 0; i < 48; i++) s[47 - i] = cd[56 - PC2_REF[i]];
    return s;
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic load_key(input logic [63:0] k, input logic dec);
    @(negedge clk);
    key_load = 1'b1;
    key_in   = k;
    decrypt  = dec;
    @(negedge clk);
    key_load = 1'b0;
  endtask

  // one round: strobe sampled at edge E0, new subkey after edge E1
  task automatic do_round(input string req, input logic [47:0] exp);
    @(negedge clk);
    round_adv = 1'b1;
    @(negedge clk);
    round_adv = 1'b0;
    check("R5 valid low during step", {63'd0, subkey_vld}, 64'd0);
    @(negedge clk);
    check("R5 valid high after step", {63'd0, subkey_vld}, 64'd1);
    check(req, {16'd0, subkey}, {16'd0, exp});
  endtask

  task automatic t_reset();
    check("R1 reset valid", {63'd0, subkey_vld}, 64'd0);
    check("R1 reset subkey", {16'd0, subkey}, 64'd0);
  endtask

  task automatic t_kat();
    load_key(64'h1334_5779_9BBC_DFF1, 1'b0);
    check("R8 load clears valid", {63'd0, subkey_vld}, 64'd0);
    do_round("R3 known first subkey", 48'h1B02_EFFC_7072);
  endtask

  task automatic t_encrypt(input logic [63:0] k);
    load_key(k, 1'b0);
    for (int n = 1; n <= 16; n++) do_round("R3 encrypt order", ref_sub(k, n));
    // R9: after a full pass the halves are back at their loaded values
    check("R9 closing subkey equals loaded", {16'd0, subkey}, {16'd0, ref_sub(k, 0)});
  endtask

  task automatic t_decrypt(input logic [63:0] k);
    load_key(k, 1'b1);
    for (int n = 1; n <= 16; n++) do_round("R4 decrypt order", ref_sub(k, 17 - n));
  endtask

  task automatic t_parity(input logic [63:0] k);
    load_key(k ^ 64'h0101_0101_0101_0101, 1'b0);
    for (int n = 1; n <= 16; n++) do_round("R2 parity ignored", ref_sub(k, n));
  endtask

  task automatic t_ignored();
    logic [47:0] last;
    load_key(64'h0123_4567_89AB_CDEF, 1'b0);
    // strobe held through the second sub-step: only one round may advance
    @(negedge clk);
    round_adv = 1'b1;
    @(negedge clk);
    @(negedge clk);
    round_adv = 1'b0;
    check("R6 busy strobe ignored", {16'd0, subkey}, {16'd0, ref_sub(64'h0123_4567_89AB_CDEF, 1)});
    for (int n = 2; n <= 16; n++) do_round("R6 rounds after busy strobe", ref_sub(64'h0123_4567_89AB_CDEF, n));
    last = subkey;
    @(negedge clk);
    round_adv = 1'b1;
    repeat (3) @(negedge clk);
    round_adv = 1'b0;
    repeat (2) @(negedge clk);
    check("R6 strobe after pass ignored", {16'd0, subkey}, {16'd0, last});
    check("R6 valid holds after pass", {63'd0, subkey_vld}, 64'd1);
  endtask

  task automatic t_dir_latched(input logic [63:0] k);
    load_key(k, 1'b1);
    decrypt = 1'b0;
    for (int n = 1; n <= 4; n++) do_round("R7 direction held", ref_sub(k, 17 - n));
  endtask

  task automatic t_load_priority(input logic [63:0] k);
    load_key(64'hFFFF_0000_FFFF_0000, 1'b0);
    do_round("R3 pre-load round", ref_sub(64'hFFFF_0000_FFFF_0000, 1));
    @(negedge clk);
    key_load  = 1'b1;
    key_in    = k;
    decrypt   = 1'b0;
    round_adv = 1'b1;
    @(negedge clk);
    key_load  = 1'b0;
    round_adv = 1'b0;
    check("R8 load wins over strobe", {63'd0, subkey_vld}, 64'd0);
    do_round("R8 first round of new pass", ref_sub(k, 1));
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    key_load  = 1'b0;
    key_in    = '0;
    decrypt   = 1'b0;
    round_adv = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_kat();
    t_encrypt(64'h1334_5779_9BBC_DFF1);
    t_encrypt(64'h0E32_9232_EA6D_0D73);
    t_decrypt(64'h1334_5779_9BBC_DFF1);
    t_decrypt(64'hA5C3_0F96_1E2D_784B);
    t_parity(64'h5B5A_5767_6A56_676E);
    t_ignored();
    t_dir_latched(64'h0E32_9232_EA6D_0D73);
    t_load_priority(64'h8001_2345_6789_ABCD);
    summary();
    $finish;
  end
endmodule